// File: doc/BRIEF.md
# Serial Command Word Receiver

This block sits on the receiving end of a serial link from a host controller. The link has one clock line and one data line, and a chip select that is active low. Each time the chip select goes low, the block collects exactly sixteen bits on the rising edges of the serial clock. The high nibble of the word is a command code and the remaining twelve bits are its argument. When a word is complete, the block presents it on parallel outputs with a one-cycle strobe. If the command is the set-configuration code, the block also copies the low byte of the argument into a configuration register that drives the rest of the design.

The serial clock is not used as a clock. A faster system clock samples the serial clock, data and select lines through two-flop synchronisers and finds the serial clock edges in its own domain. The system clock must run at least four times as fast as the serial clock. The serial clock idles low, and the host changes data on the falling edge.

Top module: `spi_cmd_rx`

## Requirements
- R1: While `rst_n` is low and after it is released, `word_valid` is 0 and `cmd`, `data` and `cfg` are all zero until a complete word arrives.
- R2: While `cs_n` is low, bits are taken from `mosi` on rising `sck` edges, most significant bit first. The first four bits form `cmd` (word bits 15:12) and the next twelve form `data` (word bits 11:0).
- R3: `word_valid` is high for exactly one `clk` cycle for each complete word. It rises at the third rising `clk` edge after the rising `sck` edge that carries the sixteenth bit, and `cmd`/`data` take the new word at that same edge.
- R4: A word whose command is 4'h1 (set-configuration) loads `data[7:0]` into `cfg` at the edge where `word_valid` rises. Words with any other command leave `cfg` unchanged.
- R5: If `cs_n` returns high before sixteen bits have arrived, the partial frame is dropped. No strobe is produced, `cmd`, `data` and `cfg` keep their values, and the next frame is assembled from its own first bit.
- R6: Rising `sck` edges after the sixteenth bit of a frame are ignored until `cs_n` goes high. They produce no second strobe and leave the outputs unchanged.
- R7: `cmd` and `data` hold their values between strobes.
- R8: `sck` activity while `cs_n` is high has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low frame select |
| word_valid | output | 1 | One-cycle strobe for a complete word |
| cmd | output | 4 | Command field of the last complete word |
| data | output | 12 | Data field of the last complete word |
| cfg | output | 8 | Configuration register |

## Verification
The bench sends full words with several command codes and varied data patterns: all ones, alternating bits, and a configuration payload with its upper argument bits set. These show that the bit order is correct, that the field split is correct, and that only the set-configuration code loads the register, and only its low byte. A seven-bit frame followed at once by a full frame shows whether the bit counter restarts on each select. A twenty-bit frame checks that extra clocks after the sixteenth bit are ignored. Clock toggles with the select inactive check that an idle bus has no effect. A reference model predicts the strobe cycle and the output values, and they are compared on every clock.

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int CMD_W = 4,
  parameter int DATA_W = 12,
  parameter int CFG_W = 8,
  parameter logic [CMD_W-1:0] CFG_CMD = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              word_valid,
  output logic [CMD_W-1:0]  cmd,
  output logic [DATA_W-1:0] data,
  output logic [CFG_W-1:0]  cfg
);
  localparam int WORD_W = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [2:0] sck_q;
  logic [1:0] mosi_q;
  logic [1:0] cs_q;
  logic [WORD_W-2:0] shreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      cs_q   <= '1;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
      cs_q   <= {cs_q[0], cs_n};
    end
  end

  wire selected = ~cs_q[1];
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire take_bit = selected && sck_rise && (cnt != CNT_W'(WORD_W));
  wire last_bit = take_bit && (cnt == CNT_W'(WORD_W - 1));
  wire [WORD_W-1:0] word = {shreg, mosi_q[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (!selected) begin
      cnt <= '0;
    end else if (take_bit) begin
      cnt   <= cnt + 1'b1;
      shreg <= word[WORD_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      cmd        <= '0;
      data       <= '0;
      cfg        <= '0;
    end else begin
      word_valid <= last_bit;
      if (last_bit) begin
        cmd  <= word[WORD_W-1:DATA_W];
        data <= word[DATA_W-1:0];
        if (word[WORD_W-1:DATA_W] == CFG_CMD)
          cfg <= word[CFG_W-1:0];
      end
    end
  end

  assert_strobe_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(cmd) && $stable(data)));

  assert_cfg_only_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(cfg));

  assert_cfg_tracks_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && cmd == CFG_CMD) |-> (cfg == data[CFG_W-1:0]));

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));

  assert_no_strobe_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |=> !word_valid);
endmodule

// File: tb/test_spi_cmd_rx.sv
module test_spi_cmd_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic cs_n = 1'b1;
  logic word_valid;
  logic [3:0] cmd;
  logic [11:0] data;
  logic [7:0] cfg;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int due_q[$];
  logic [15:0] word_q[$];
  logic exp_v = 1'b0;
  logic [3:0] exp_cmd = '0;
  logic [11:0] exp_data = '0;
  logic [7:0] exp_cfg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_rx i_spi_cmd_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .word_valid(word_valid), .cmd(cmd), .data(data), .cfg(cfg)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Reference model: predicts strobe cycle and held values; compared each clock.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      cyc++;
      exp_v = 1'b0;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        logic [15:0] w;
        w = word_q.pop_front();
        void'(due_q.pop_front());
        exp_v = 1'b1;
        exp_cmd = w[15:12];
        exp_data = w[11:0];
        if (w[15:12] == 4'h1) exp_cfg = w[7:0];
      end
      check("R3", "word_valid", int'(word_valid), int'(exp_v));
      check("R2", "cmd", int'(cmd), int'(exp_cmd));
      check("R7", "data", int'(data), int'(exp_data));
      check("R4", "cfg", int'(cfg), int'(exp_cfg));
    end
  end

  task automatic frame(input int nbits, input logic [31:0] bits);
    logic [15:0] w = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[nbits-1-i];
      if (i < 16) w = {w[14:0], mosi};
      repeat (3) @(negedge clk);
      sck = 1'b1;
      if (i == 15) begin
        due_q.push_back(cyc + 3);
        word_q.push_back(w);
      end
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = i[0];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: cycles=%0d expected under 100000", cyc);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset word_valid", int'(word_valid), 0);
    check("R1", "reset cmd", int'(cmd), 0);
    check("R1", "reset data", int'(data), 0);
    check("R1", "reset cfg", int'(cfg), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);

    frame(16, 32'h0000_1ABC);   // R4: cfg <= 8'hBC
    frame(16, 32'h0000_7FFF);   // R2 all ones data, cfg unchanged (R4)
    frame(16, 32'h0000_A555);   // R2 alternating pattern
    frame(7,  32'h0000_0055);   // R5 short frame dropped
    frame(16, 32'h0000_1035);   // R5 next frame starts clean, cfg <= 35
    frame(20, 32'h0002_C3D5);   // R6 extra bits: word 16'h2C3D
    idle_clocks(6);             // R8 sck while deselected
    frame(16, 32'h0000_1F0E);   // R4 cfg <= 0E
    frame(16, 32'h0000_0000);   // R2 zero word, cmd 0
    frame(3,  32'h0000_0007);   // R5 short frame
    idle_clocks(3);             // R8
    frame(16, 32'h0000_F123);   // R2 highest command code

    repeat (10) @(negedge clk);
    check("R5", "pending words", due_q.size(), 0);
    report();
  end
endmodule